// File: doc/BRIEF.md
# Gamma Line Latch with Polarity Bank Control

This block sits behind the full-line data register of a column driver. On every line strobe it copies the whole line of 6-bit gray codes into an output latch and captures the polarity input at the same moment. It then decodes each channel's code into the selection controls for the reference ladder. These controls are the reference bank, the reference tap that starts the code's segment, the segment number, the step within that segment, and a flag for codes that sit exactly on a tap.

Neighbouring channels always draw from opposite reference banks. The polarity input chooses which of the two gets the upper bank. Each channel has a drive enable. It is low while the strobe is high, which models the high-impedance window, and it comes back high once the strobe falls. After reset the outputs stay undriven until the first complete strobe pulse. All inputs are sampled on the rising edge of `clk_i`.

Top module: `gamma_line_latch`

## Requirements
- R1: After reset, `drive_en_o` is all zeros. It stays all zeros until the first clock edge at which the strobe is sampled low after having been sampled high.
- R2: At a rising strobe (sampled high after a low sample), every channel's code is captured from `line_data_i`. Channel k occupies bits [6k+5:6k]. The decoded outputs reflect the captured codes from the next cycle. They do not change at any other time, whatever `line_data_i` does.
- R3: On every cycle that follows a clock edge with the strobe sampled high, `drive_en_o` is all zeros.
- R4: On the cycle that follows the first edge with the strobe sampled low after a high sample, `drive_en_o` is all ones. It holds that value until the strobe is sampled high again.
- R5: `bank_o[k]` is 1 for the upper bank (references 0 to 4) and 0 for the lower bank (references 5 to 9). With captured polarity 0, channels with even k use the upper bank and channels with odd k use the lower bank. With captured polarity 1 the assignment is swapped.
- R6: The polarity is captured only at a rising strobe. Later changes of `pol_i`, including changes while the strobe is still high, do not alter `bank_o`.
- R7: `seg_o` for channel k equals code bits [5:4]. `step_o` equals code bits [3:0].
- R8: For an upper-bank channel, `ref_o` equals the segment number, giving 0, 1, 2 or 3. Code 3Fh gives 4.
- R9: For a lower-bank channel, `ref_o` equals 9 minus the segment number, giving 9, 8, 7 or 6. Code 3Fh gives 5.
- R10: `tap_o` is 1 exactly when the code's low four bits are zero or the code is 3Fh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Line strobe |
| pol_i | input | 1 | Polarity select, captured at strobe rise |
| line_data_i | input | 6*NUM_CH | Full-line register contents, 6 bits per channel |
| bank_o | output | NUM_CH | 1 selects the upper reference bank |
| ref_o | output | 4*NUM_CH | Reference tap number at the segment start (or the end tap for 3Fh) |
| seg_o | output | 2*NUM_CH | Segment number within the bank |
| step_o | output | 4*NUM_CH | Step within the segment |
| tap_o | output | NUM_CH | Code sits exactly on a reference tap |
| drive_en_o | output | NUM_CH | Output driven (0 means high impedance) |

## Verification
The assertions take for granted that each strobe pulse stays high for at least two clocks. They also take for granted that the strobe is a clean synchronous level, so each rise and each fall is seen at exactly one clock edge. The stimulus keeps every strobe high for two or more cycles and changes inputs only between edges. It moves `pol_i` and `line_data_i` only outside the capture edge, so every capture is unambiguous. Some of these changes fall inside the strobe window on purpose, to show they are ignored.

// File: rtl/gamma_line_pkg.sv
package gamma_line_pkg;
  localparam int CODE_W  = 6;
  localparam int SEG_W   = 2;
  localparam int STEP_W  = CODE_W - SEG_W;
  localparam int NUM_SEG = 1 << SEG_W;
  localparam int REF_W   = 4;
  // references 0..NUM_SEG are upper bank, the rest lower bank
  localparam int UP_END  = NUM_SEG;
  localparam int LO_TOP  = 2 * NUM_SEG + 1;
  localparam int LO_END  = NUM_SEG + 1;

  typedef struct packed {
    logic [REF_W-1:0]  ref_idx;
    logic [SEG_W-1:0]  seg;
    logic [STEP_W-1:0] step;
    logic              tap;
  } chan_sel_t;
endpackage

// File: rtl/gamma_strobe_ctrl.sv
module gamma_strobe_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic load_o,
  output logic drive_o
);
  logic strb_q, drive_q;

  assign load_o  = strobe_i & ~strb_q;
  assign drive_o = drive_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strb_q  <= 1'b0;
      drive_q <= 1'b0;
    end else begin
      strb_q <= strobe_i;
      if (strobe_i)    drive_q <= 1'b0;
      else if (strb_q) drive_q <= 1'b1;
    end
  end
endmodule

// File: rtl/gamma_line_store.sv
module gamma_line_store #(
  parameter int NUM_CH = 8,
  parameter int CODE_W = 6,
  localparam int LINE_W = NUM_CH * CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              pol_i,
  input  logic [LINE_W-1:0] data_i,
  output logic [LINE_W-1:0] data_o,
  output logic              pol_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      pol_o  <= 1'b0;
    end else if (load_i) begin
      data_o <= data_i;
      pol_o  <= pol_i;
    end
  end
endmodule

// File: rtl/gamma_seg_decode.sv
module gamma_seg_decode
  import gamma_line_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic              upper_i,
  output chan_sel_t         sel_o
);
  logic [SEG_W-1:0]  seg;
  logic [STEP_W-1:0] step;
  logic              last;

  assign seg  = code_i[CODE_W-1:STEP_W];
  assign step = code_i[STEP_W-1:0];
  assign last = &code_i;

  always_comb begin
    sel_o.seg  = seg;
    sel_o.step = step;
    sel_o.tap  = (step == '0) | last;
    if (last)
      sel_o.ref_idx = upper_i ? REF_W'(UP_END) : REF_W'(LO_END);
    else if (upper_i)
      sel_o.ref_idx = REF_W'(seg);
    else
      sel_o.ref_idx = REF_W'(LO_TOP) - REF_W'(seg);
  end
endmodule

// File: rtl/gamma_line_latch.sv
module gamma_line_latch
  import gamma_line_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int LINE_W = NUM_CH * CODE_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      strobe_i,
  input  logic                      pol_i,
  input  logic [LINE_W-1:0]         line_data_i,
  output logic [NUM_CH-1:0]         bank_o,
  output logic [NUM_CH*REF_W-1:0]   ref_o,
  output logic [NUM_CH*SEG_W-1:0]   seg_o,
  output logic [NUM_CH*STEP_W-1:0]  step_o,
  output logic [NUM_CH-1:0]         tap_o,
  output logic [NUM_CH-1:0]         drive_en_o
);
  logic              load, drive;
  logic [LINE_W-1:0] line_q;
  logic              pol_q;

  gamma_strobe_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(strobe_i),
    .load_o  (load),
    .drive_o (drive)
  );

  gamma_line_store #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_store (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .pol_i (pol_i),
    .data_i(line_data_i),
    .data_o(line_q),
    .pol_o (pol_q)
  );

  assign drive_en_o = {NUM_CH{drive}};

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic      upper;
    chan_sel_t sel;
    // even channels take the upper bank at polarity 0
    if (k % 2 == 0) begin : g_even
      assign upper = ~pol_q;
    end else begin : g_odd
      assign upper = pol_q;
    end

    gamma_seg_decode u_dec (
      .code_i (line_q[k*CODE_W +: CODE_W]),
      .upper_i(upper),
      .sel_o  (sel)
    );

    assign bank_o[k]                 = upper;
    assign ref_o[k*REF_W +: REF_W]   = sel.ref_idx;
    assign seg_o[k*SEG_W +: SEG_W]   = sel.seg;
    assign step_o[k*STEP_W +: STEP_W] = sel.step;
    assign tap_o[k]                  = sel.tap;
  end
endmodule

// File: rtl/gamma_line_chk.sv
module gamma_line_chk
  import gamma_line_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     strobe_i,
  input logic [NUM_CH*CODE_W-1:0] line_data_i,
  input logic [NUM_CH-1:0]        bank_o,
  input logic [NUM_CH*SEG_W-1:0]  seg_o,
  input logic [NUM_CH*STEP_W-1:0] step_o,
  input logic [NUM_CH-1:0]        drive_en_o
);
  logic prev_q, fell_seen_q;
  logic rise, fall;

  assign rise = strobe_i & ~prev_q;
  assign fall = ~strobe_i & prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q      <= 1'b0;
      fell_seen_q <= 1'b0;
    end else begin
      prev_q <= strobe_i;
      if (fall) fell_seen_q <= 1'b1;
    end
  end

  AST_HIZ_UNTIL_FIRST_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fell_seen_q && !fall) |=> (drive_en_o == '0)); // R1

  AST_HIZ_IN_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> (drive_en_o == '0)); // R3

  AST_DRIVE_AFTER_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall |=> (&drive_en_o)); // R4

  AST_LOAD_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> ({seg_o[SEG_W-1:0], step_o[STEP_W-1:0]} == $past(line_data_i[CODE_W-1:0]))); // R2

  AST_HOLD_CODES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise |=> ($stable(seg_o) && $stable(step_o))); // R2

  AST_HOLD_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise |=> $stable(bank_o)); // R6
endmodule

bind gamma_line_latch gamma_line_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .strobe_i   (strobe_i),
  .line_data_i(line_data_i),
  .bank_o     (bank_o),
  .seg_o      (seg_o),
  .step_o     (step_o),
  .drive_en_o (drive_en_o)
);

// File: tb/gamma_line_latch_test.sv
`timescale 1ns/1ps
module gamma_line_latch_test;
  localparam int NCH = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            strobe = 1'b0;
  logic            pol = 1'b0;
  logic [NCH*6-1:0] line_data = '0;
  logic [NCH-1:0]   bank, tap, drive_en;
  logic [NCH*4-1:0] refo, step;
  logic [NCH*2-1:0] seg;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gamma_line_latch #(.NUM_CH(NCH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .pol_i(pol),
    .line_data_i(line_data), .bank_o(bank), .ref_o(refo), .seg_o(seg),
    .step_o(step), .tap_o(tap), .drive_en_o(drive_en)
  );

  // {pol, ch3, ch2, ch1, ch0}
  localparam logic [24:0] VEC [6] = '{
    {1'b0, 6'h30, 6'h20, 6'h10, 6'h00},
    {1'b0, 6'h2F, 6'h1F, 6'h0F, 6'h3F},
    {1'b1, 6'h30, 6'h20, 6'h10, 6'h00},
    {1'b1, 6'h15, 6'h2A, 6'h01, 6'h3F},
    {1'b0, 6'h00, 6'h00, 6'h3F, 6'h3F},
    {1'b1, 6'h3E, 6'h2F, 6'h1F, 6'h0F}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // model of the decoded outputs for all channels: R5 R7 R8 R9 R10
  task automatic check_decode(logic [NCH*6-1:0] data, logic p);
    for (int k = 0; k < NCH; k++) begin
      logic [5:0] c;
      logic       up;
      logic [3:0] r;
      c  = data[k*6 +: 6];
      up = (k % 2 == 0) ? ~p : p;
      if (c == 6'h3F) r = up ? 4'd4 : 4'd5;
      else            r = up ? {2'b00, c[5:4]} : 4'd9 - {2'b00, c[5:4]};
      chk("R5 bank", 32'(bank[k]), 32'(up));
      chk("R7 seg/step", 32'({seg[k*2 +: 2], step[k*4 +: 4]}), 32'(c));
      chk(up ? "R8 upper ref" : "R9 lower ref", 32'(refo[k*4 +: 4]), 32'(r));
      chk("R10 tap", 32'(tap[k]), 32'((c[3:0] == 4'd0) || (c == 6'h3F)));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200_000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [NCH*6-1:0] held;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    chk("R1 drive after reset", 32'(drive_en), 0);
    // data moves without a strobe: outputs stay at reset contents
    line_data = 24'hABCDEF;
    tick(); tick();
    chk("R1 still hi-z", 32'(drive_en), 0);
    chk("R2 no capture without strobe", 32'(seg), 0);

    // table walk
    for (int v = 0; v < 6; v++) begin
      pol = VEC[v][24];
      line_data = VEC[v][23:0];
      strobe = 1'b1;
      tick();
      chk("R3 hi-z after rise", 32'(drive_en), 0);
      check_decode(VEC[v][23:0], VEC[v][24]);
      tick();
      chk("R3 hi-z second cycle", 32'(drive_en), 0);
      strobe = 1'b0;
      tick();
      chk("R4 driven after fall", 32'(drive_en), 32'((1 << NCH) - 1));
    end

    // inputs move between strobes: nothing changes
    held = VEC[5][23:0];
    pol = 1'b0;
    line_data = 24'h123456;
    tick(); tick(); tick();
    chk("R4 drive held", 32'(drive_en), 32'((1 << NCH) - 1));
    check_decode(held, 1'b1);   // R2 R6

    // long strobe; pol and data move while it is high
    pol = 1'b1;
    line_data = {6'h3F, 6'h00, 6'h3F, 6'h10};
    strobe = 1'b1;
    tick();
    pol = 1'b0;
    line_data = 24'hFFFFFF;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R3 long strobe hi-z", 32'(drive_en), 0);
    end
    strobe = 1'b0;
    tick();
    chk("R4 long strobe fall", 32'(drive_en), 32'((1 << NCH) - 1));
    check_decode({6'h3F, 6'h00, 6'h3F, 6'h10}, 1'b1); // R6 R2

    // reset mid-run
    rst_n = 1'b0;
    #1;
    chk("R1 async reset", 32'(drive_en), 0);
    tick();
    rst_n = 1'b1;
    tick();
    chk("R1 hi-z after re-reset", 32'(drive_en), 0);
    finish_run();
  end
endmodule